// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block tracks reservations for load-linked / store-conditional read-modify-write on a single core. The processor presents one request per cycle on a small request interface: exclusive load, exclusive store, plain store, clear-reservation or exception entry, each with an address and, for stores, write data. The monitor keeps an open/exclusive state and, when tagging is enabled, the word-granule address of the reservation. For each exclusive store it decides whether the write reaches memory, gates the memory write enable in the same cycle, and reports the outcome one cycle later.

Software uses it in a retry loop. It loads exclusively, computes a new value, stores exclusively, and retries when the status says the store failed. Any exclusive store, any clear request and any exception entry drop the reservation. As a result, an interrupted sequence fails once and succeeds when it is retried. A per-request attribute marks the target as shareable with no global monitor attached, and every exclusive store to such a target fails. A parameter chooses between the tagged variant and a simple variant that ignores addresses.

Top module: `excl_mon`

## Requirements
- R1: After synchronous reset the monitor is open with its tag cleared and the done strobe is low, so the first exclusive store fails.
- R2: Request kinds are encoded as 0 idle, 1 exclusive load, 2 exclusive store, 3 plain store, 4 clear-reservation, 5 exception entry. An exclusive load taken while the monitor is open makes it exclusive, and a following exclusive store to the same word then commits its data to memory.
- R3: Every exclusive store returns the monitor to open, whether it commits or not, so a second exclusive store with no new exclusive load fails.
- R4: An exclusive store made while the monitor is open does not assert the memory write enable and reports failure.
- R5: With tagging disabled, an exclusive store succeeds whenever the monitor is exclusive, even when its address differs from that of the last exclusive load.
- R6: With tagging enabled, an exclusive load to a word other than the tagged one, made while exclusive, leaves the monitor open. A repeated exclusive load to the tagged word keeps it exclusive. An exclusive store to a word other than the tagged one fails.
- R7: A clear-reservation request makes the monitor open.
- R8: An exception-entry request makes the monitor open, so an exclusive store that was interrupted fails.
- R9: An exclusive store that carries the shareable-without-global-monitor attribute always fails and writes nothing.
- R10: A plain store asserts the memory write enable in its request cycle and leaves the monitor state unchanged, including when it hits the tagged word.
- R11: The memory write enable for a request is driven in the same cycle as the request. The done strobe is high for exactly the one cycle after each exclusive store, and the status output is 0 for success and 1 for failure.
- R12: In a nested interrupt, the interrupting context completes its own exclusive pair. The interrupted context then fails once, succeeds on retry, and memory holds both increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 3 | Request kind (encoding in R2) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| req_no_global | input | 1 | Target is shareable with no global monitor |
| mem_we | output | 1 | Memory write enable, same cycle as request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| xs_done | output | 1 | Exclusive store result strobe |
| xs_status | output | 1 | 0 success, 1 failure, valid with xs_done |

## Verification
The assertions assume that at most one request arrives per cycle and that a request is held for exactly one cycle, with kind codes limited to 0 through 5. The bench drives each request for a single cycle on the falling edge and draws kinds only from the defined codes. Its addresses are word aligned and come from a small pool, so that tag hits and tag misses both occur often. The shareable-without-global attribute is set on roughly one exclusive store in eight.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [2:0] {
        REQ_IDLE   = 3'd0,
        REQ_LDEX   = 3'd1,
        REQ_STEX   = 3'd2,
        REQ_STORE  = 3'd3,
        REQ_CLREX  = 3'd4,
        REQ_EXCEPT = 3'd5
    } req_kind_e;

    typedef enum logic {
        MON_OPEN = 1'b0,
        MON_EXCL = 1'b1
    } mon_state_e;

    localparam logic STATUS_OK   = 1'b0;
    localparam logic STATUS_FAIL = 1'b1;

    function automatic logic kind_drops_reservation(req_kind_e k);
        return (k == REQ_STEX) || (k == REQ_CLREX) || (k == REQ_EXCEPT);
    endfunction

    function automatic logic kind_writes_always(req_kind_e k);
        return k == REQ_STORE;
    endfunction

endpackage

// File: rtl/excl_mon_state.sv
module excl_mon_state
    import excl_mon_pkg::*;
#(
    parameter int TAG_W  = 30,
    parameter int TAGGED = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  req_kind_e        kind,
    input  logic [TAG_W-1:0] tag_in,
    output mon_state_e       state_q,
    output logic [TAG_W-1:0] tag_q
);

    mon_state_e       state_d;
    logic [TAG_W-1:0] tag_d;
    mon_state_e       ld_next;
    logic [TAG_W-1:0] ld_tag;

    generate
        if (TAGGED != 0) begin : g_tagged
            always_comb begin
                ld_next = MON_EXCL;
                ld_tag  = tag_in;
                if (state_q == MON_EXCL && tag_q != tag_in) begin
                    ld_next = MON_OPEN;
                    ld_tag  = '0;
                end
            end
        end else begin : g_simple
            assign ld_next = MON_EXCL;
            assign ld_tag  = tag_in;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        if (req_valid) begin
            if (kind == REQ_LDEX) begin
                state_d = ld_next;
                tag_d   = ld_tag;
            end else if (kind_drops_reservation(kind)) begin
                state_d = MON_OPEN;
                tag_d   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MON_OPEN;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    assert_ldex_opens_excl_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == REQ_LDEX && state_q == MON_OPEN) |=> state_q == MON_EXCL);

    assert_stex_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == REQ_STEX) |=> state_q == MON_OPEN);

    assert_clrex_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == REQ_CLREX) |=> state_q == MON_OPEN);

    assert_except_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == REQ_EXCEPT) |=> state_q == MON_OPEN);

    assert_store_keeps_state_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == REQ_STORE) |=> state_q == $past(state_q));

    generate
        if (TAGGED != 0) begin : g_tag_chk
            assert_ldex_mismatch_open_R6: assert property (@(posedge clk) disable iff (rst)
                (req_valid && kind == REQ_LDEX && state_q == MON_EXCL && tag_q != tag_in)
                |=> state_q == MON_OPEN);
        end
    endgenerate

endmodule

// File: rtl/excl_mon_decide.sv
module excl_mon_decide
    import excl_mon_pkg::*;
#(
    parameter int TAG_W  = 30,
    parameter int TAGGED = 1
) (
    input  mon_state_e       state_q,
    input  logic [TAG_W-1:0] tag_q,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             no_global,
    output logic             stex_pass
);

    logic tag_ok;

    assign tag_ok    = (TAGGED == 0) || (tag_q == tag_in);
    assign stex_pass = (state_q == MON_EXCL) && tag_ok && !no_global;

endmodule

// File: rtl/excl_mon_resp.sv
module excl_mon_resp
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  req_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stex_pass,
    input  mon_state_e        state_q,
    input  logic              no_global,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done,
    output logic              status
);

    logic is_stex;

    assign is_stex   = req_valid && (kind == REQ_STEX);
    assign mem_we    = (req_valid && kind_writes_always(kind)) || (is_stex && stex_pass);
    assign mem_addr  = addr;
    assign mem_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            status <= STATUS_OK;
        end else begin
            done   <= is_stex;
            status <= (is_stex && !stex_pass) ? STATUS_FAIL : STATUS_OK;
        end
    end

    assert_open_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (is_stex && state_q == MON_OPEN) |-> !mem_we);

    assert_open_fails_R4: assert property (@(posedge clk) disable iff (rst)
        (is_stex && state_q == MON_OPEN) |=> (done && status == STATUS_FAIL));

    assert_no_global_R9: assert property (@(posedge clk) disable iff (rst)
        (is_stex && no_global) |-> !mem_we);

    assert_done_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(is_stex));

    assert_plain_store_writes_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == REQ_STORE) |-> mem_we);

endmodule

// File: rtl/excl_mon.sv
module excl_mon
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int GRAN_LSB = 2,
    parameter int TAGGED   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_no_global,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              xs_done,
    output logic              xs_status
);

    localparam int TAG_W = ADDR_W - GRAN_LSB;

    req_kind_e        kind;
    logic [TAG_W-1:0] tag_in;
    mon_state_e       state_q;
    logic [TAG_W-1:0] tag_q;
    logic             stex_pass;

    always_comb begin
        case (req_kind)
            3'd1:    kind = REQ_LDEX;
            3'd2:    kind = REQ_STEX;
            3'd3:    kind = REQ_STORE;
            3'd4:    kind = REQ_CLREX;
            3'd5:    kind = REQ_EXCEPT;
            default: kind = REQ_IDLE;
        endcase
    end

    assign tag_in = req_addr[ADDR_W-1:GRAN_LSB];

    excl_mon_state #(.TAG_W(TAG_W), .TAGGED(TAGGED)) u_state (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .kind      (kind),
        .tag_in    (tag_in),
        .state_q   (state_q),
        .tag_q     (tag_q)
    );

    excl_mon_decide #(.TAG_W(TAG_W), .TAGGED(TAGGED)) u_decide (
        .state_q   (state_q),
        .tag_q     (tag_q),
        .tag_in    (tag_in),
        .no_global (req_no_global),
        .stex_pass (stex_pass)
    );

    excl_mon_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .kind      (kind),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .stex_pass (stex_pass),
        .state_q   (state_q),
        .no_global (req_no_global),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (xs_done),
        .status    (xs_status)
    );

    assert_reset_open_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == MON_OPEN && !xs_done));

endmodule

// File: tb/excl_mon_bench.sv
module excl_mon_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_no_global = 1'b0;

    logic        t_we, u_we, t_done, u_done, t_status, u_status;
    logic [31:0] t_addr, u_addr, t_wdata, u_wdata;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] mem [16];

    logic        m_ex;
    logic [29:0] m_tag;
    logic        s_ex;

    always #4 clk = ~clk;

    excl_mon #(.TAGGED(1)) u_excl_mon (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_no_global(req_no_global),
        .mem_we(t_we), .mem_addr(t_addr), .mem_wdata(t_wdata),
        .xs_done(t_done), .xs_status(t_status)
    );

    excl_mon #(.TAGGED(0)) u_excl_mon_simple (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_no_global(req_no_global),
        .mem_we(u_we), .mem_addr(u_addr), .mem_wdata(u_wdata),
        .xs_done(u_done), .xs_status(u_status)
    );

    always @(posedge clk) begin
        if (t_we) mem[t_addr[5:2]] <= t_wdata;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One request for one cycle; called at a falling edge, returns at a falling edge.
    task automatic op(input string req, input logic [2:0] k, input logic [31:0] a,
                      input logic [31:0] d, input logic ng);
        logic pass_t, pass_s, we_t, we_s;
        pass_t = m_ex && (m_tag == a[31:2]) && !ng;
        pass_s = s_ex && !ng;
        we_t = (k == 3'd3) || (k == 3'd2 && pass_t);
        we_s = (k == 3'd3) || (k == 3'd2 && pass_s);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d; req_no_global = ng;
        #1;
        chk(req, "we tagged", {31'd0, t_we}, {31'd0, we_t});
        chk(req, "we simple", {31'd0, u_we}, {31'd0, we_s});
        @(posedge clk);
        case (k)
            3'd1: begin
                if (m_ex && m_tag != a[31:2]) begin m_ex = 1'b0; m_tag = '0; end
                else begin m_ex = 1'b1; m_tag = a[31:2]; end
                s_ex = 1'b1;
            end
            3'd2, 3'd4, 3'd5: begin m_ex = 1'b0; m_tag = '0; s_ex = 1'b0; end
            default: ;
        endcase
        @(negedge clk);
        chk(req, "done tagged", {31'd0, t_done}, {31'd0, (k == 3'd2)});
        chk(req, "done simple", {31'd0, u_done}, {31'd0, (k == 3'd2)});
        if (k == 3'd2) begin
            chk(req, "status tagged", {31'd0, t_status}, {31'd0, !pass_t});
            chk(req, "status simple", {31'd0, u_status}, {31'd0, !pass_s});
        end
        req_valid = 1'b0; req_kind = 3'd0; req_no_global = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 16; i++) mem[i] = '0;
        m_ex = 1'b0; m_tag = '0; s_ex = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "done after reset", {31'd0, t_done}, 32'd0);
        chk("R1", "we idle", {31'd0, t_we}, 32'd0);
        op("R1", 3'd2, 32'h10, 32'hdead, 1'b0);

        // R2 / R11: basic successful pair
        op("R2", 3'd1, 32'h10, 0, 1'b0);
        op("R2", 3'd2, 32'h10, 32'h1111, 1'b0);
        chk("R2", "mem word", mem[4], 32'h1111);
        // R3: second store fails
        op("R3", 3'd2, 32'h10, 32'h2222, 1'b0);
        chk("R3", "mem unchanged", mem[4], 32'h1111);
        // R4: store while open
        op("R4", 3'd4, 32'h10, 0, 1'b0);
        op("R4", 3'd2, 32'h10, 32'h3333, 1'b0);
        chk("R4", "mem unchanged", mem[4], 32'h1111);
        // R5: address-agnostic success when untagged
        op("R5", 3'd1, 32'h10, 0, 1'b0);
        op("R5", 3'd2, 32'h20, 32'h5555, 1'b0);
        // R6: tagged reload rules
        op("R6", 3'd1, 32'h14, 0, 1'b0);
        op("R6", 3'd1, 32'h14, 0, 1'b0);
        op("R6", 3'd2, 32'h14, 32'h6666, 1'b0);
        chk("R6", "mem word", mem[5], 32'h6666);
        op("R6", 3'd1, 32'h14, 0, 1'b0);
        op("R6", 3'd1, 32'h20, 0, 1'b0);
        op("R6", 3'd2, 32'h20, 32'h7777, 1'b0);
        // R7 / R8
        op("R7", 3'd1, 32'h18, 0, 1'b0);
        op("R7", 3'd4, 32'h18, 0, 1'b0);
        op("R7", 3'd2, 32'h18, 32'h8888, 1'b0);
        op("R8", 3'd1, 32'h18, 0, 1'b0);
        op("R8", 3'd5, 32'h18, 0, 1'b0);
        op("R8", 3'd2, 32'h18, 32'h9999, 1'b0);
        chk("R8", "mem word", mem[6], 32'h0);
        // R9
        op("R9", 3'd1, 32'h1c, 0, 1'b0);
        op("R9", 3'd2, 32'h1c, 32'haaaa, 1'b1);
        chk("R9", "mem word", mem[7], 32'h0);
        // R10: plain store to tagged word keeps reservation
        op("R10", 3'd1, 32'h1c, 0, 1'b0);
        op("R10", 3'd3, 32'h1c, 32'hbbbb, 1'b0);
        chk("R10", "plain store data", mem[7], 32'hbbbb);
        op("R10", 3'd2, 32'h1c, 32'hcccc, 1'b0);
        chk("R10", "stex after store", mem[7], 32'hcccc);

        // R12: nested interrupt retry
        mem[8] = 32'd40;
        op("R12", 3'd1, 32'h20, 0, 1'b0);
        v = mem[8];
        op("R12", 3'd5, 32'h20, 0, 1'b0);
        op("R12", 3'd1, 32'h20, 0, 1'b0);
        op("R12", 3'd2, 32'h20, mem[8] + 1, 1'b0);
        chk("R12", "inner stex", {31'd0, t_status}, 32'd0);
        op("R12", 3'd2, 32'h20, v + 1, 1'b0);
        chk("R12", "outer first try", {31'd0, t_status}, 32'd1);
        op("R12", 3'd1, 32'h20, 0, 1'b0);
        v = mem[8];
        op("R12", 3'd2, 32'h20, v + 1, 1'b0);
        chk("R12", "outer retry", {31'd0, t_status}, 32'd0);
        chk("R12", "final count", mem[8], 32'd42);

        // Random mix, R11 timing/status checked on every op
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  k;
            logic [31:0] a;
            logic        ng;
            k  = 3'($urandom_range(1, 5));
            a  = 32'h10 + 32'(($urandom_range(0, 2)) * 4);
            ng = (k == 3'd2) && ($urandom_range(0, 7) == 0);
            op("R11", k, a, $urandom, ng);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule